// File: doc/BRIEF.md
# UART Register and Interrupt Front-End

This block sits between a 32-bit register bus and the line engine of a UART. Software reaches it through word-indexed registers. It holds the character-length and parity configuration, which it passes on decoded to the serializer and deserializer. It buffers outgoing bytes in a transmit FIFO and incoming bytes in a receive FIFO. It reports channel state and drives one level-sensitive interrupt line. On the line side, the transmit FIFO feeds a byte stream with a valid/ready handshake. Received bytes arrive through a push strobe that carries a parity-error flag. Baud generation and the serial shifters live outside the block.

Bus accesses are handled by a two-state sequencer. In `ST_IDLE`, a request is performed at the next clock edge: a write takes effect, or read data is captured. The sequencer then moves to `ST_RESP`. In `ST_RESP`, `bus_ack` is high for exactly one cycle, and the sequencer always returns to `ST_IDLE` at the following edge. A request seen in `ST_RESP` is not taken.

Interrupt sources are latched in a status register and cleared by writing ones. A mask register gates them onto `irq`. The mask is built by writing ones to a set register and to a clear register; the mask itself is read-only.

Top module: `uart_regif`

## Requirements
- R1: After reset, the registers read as follows: mask (index 4) 0, status (index 5) 0, mode (index 1) 0x20, trigger level (index 8) FIFO_DEPTH/2. Channel status (index 11) reads 0x0A. `irq`, `tx_valid` and `bus_ack` are low.
- R2: A request accepted in `ST_IDLE` gives `bus_ack` high in the next cycle only. Read data is valid on `bus_rdata` while `bus_ack` is high.
- R3: Writing ones to index 2 sets mask bits, and writing ones to index 3 clears them. Writing all ones to index 3 clears the whole mask. Mask reads at index 4; indices 2 and 3 read as zero. Only bits 0, 3 and 7 exist.
- R4: Writing ones to status (index 5) clears those pending bits. `irq` is high exactly while status AND mask is nonzero.
- R5: When a received byte is accepted and the receive fill count after the push is at or above a nonzero trigger level, status bit 0 becomes pending. Channel status bit 0 shows whether the fill count is at or above the level. A level of 1 fires on every byte.
- R6: Status bit 3 becomes pending after the transmit FIFO goes from non-empty to empty.
- R7: Mode bits [2:1] give `cfg_bits`: 0x is 8, 10 is 7, 11 is 6. Mode bit 5 set gives `cfg_par` 2 (none). Otherwise mode bit 3 gives 1 (odd) when set and 0 (even) when clear.
- R8: A write to index 12 pushes `bus_wdata[7:0]` into the transmit FIFO, which drives `tx_data`/`tx_valid` oldest-first and pops on `tx_valid && tx_ready`. A read from index 12 pops the receive FIFO in arrival order.
- R9: A write to index 12 while the transmit FIFO is full is dropped. A read from index 12 while the receive FIFO is empty returns 0 and changes nothing. Channel status bits are: 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full.
- R10: A receive push that carries `rx_perr` and is accepted sets status bit 7. A push while the receive FIFO is full is dropped.
- R11: Writing control (index 0) with bit 0 set empties the transmit FIFO, and with bit 1 set empties the receive FIFO. The control register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle access completion |
| tx_data | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit FIFO not empty |
| tx_ready | input | 1 | Line side takes tx_data |
| rx_data | input | 8 | Received byte |
| rx_push | input | 1 | Push rx_data into receive FIFO |
| rx_perr | input | 1 | Parity error on this byte |
| cfg_bits | output | 4 | Character length in bits |
| cfg_par | output | 2 | Parity: 0 even, 1 odd, 2 none |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with FIFO_DEPTH = 8, so the reset trigger level is 4. With that depth, both FIFOs reach full after eight bytes. This brings the dropped-write, dropped-push, full-flag and threshold cases within a few dozen cycles. The trigger level is also reprogrammed to 1 to show an event on every byte, and the default depth of 64 changes only counter widths.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
    localparam logic [3:0] IDX_CTRL = 4'd0;
    localparam logic [3:0] IDX_MODE = 4'd1;
    localparam logic [3:0] IDX_IEN  = 4'd2;
    localparam logic [3:0] IDX_IDIS = 4'd3;
    localparam logic [3:0] IDX_MASK = 4'd4;
    localparam logic [3:0] IDX_STAT = 4'd5;
    localparam logic [3:0] IDX_LVL  = 4'd8;
    localparam logic [3:0] IDX_CHAN = 4'd11;
    localparam logic [3:0] IDX_DATA = 4'd12;

    localparam int EV_RXTRIG  = 0;
    localparam int EV_TXEMPTY = 3;
    localparam int EV_PERR    = 7;
    localparam logic [7:0] EV_IMPL = 8'h89;

    localparam logic [5:0] MODE_RST = 6'h20;

    typedef enum logic [1:0] {
        PAR_EVEN = 2'd0,
        PAR_ODD  = 2'd1,
        PAR_NONE = 2'd2
    } parity_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/uart_regif_fifo.sv
module uart_regif_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R9
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (count == $past(count))); // R9
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty); // R9
endmodule

// File: rtl/uart_regif_bus_fsm.sv
module uart_regif_bus_fsm
    import uart_regif_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [31:0] rd_mux,
    output logic        wr_fire,
    output logic        rd_fire,
    output logic [31:0] bus_rdata,
    output logic        bus_ack
);
    bus_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (bus_req) state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign wr_fire = (state == ST_IDLE) && bus_req && bus_we;
    assign rd_fire = (state == ST_IDLE) && bus_req && !bus_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack <= (state == ST_IDLE) && bus_req;
            if (rd_fire) bus_rdata <= rd_mux;
        end
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack); // R2
    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire || rd_fire) |=> bus_ack); // R2
endmodule

// File: rtl/uart_regif_irq.sv
module uart_regif_irq
    import uart_regif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] set_vec,
    input  logic       en_wr,
    input  logic       dis_wr,
    input  logic       clr_wr,
    input  logic [7:0] wbits,
    output logic [7:0] stat,
    output logic [7:0] mask,
    output logic       irq
);
    logic [7:0] clr_bits;

    assign clr_bits = clr_wr ? (wbits & EV_IMPL) : 8'h00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= 8'h00;
            mask <= 8'h00;
        end else begin
            stat <= (stat & ~clr_bits) | (set_vec & EV_IMPL);
            if (en_wr)       mask <= mask | (wbits & EV_IMPL);
            else if (dis_wr) mask <= mask & ~wbits;
        end
    end

    assign irq = |(stat & mask);

    AST_MASK_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_wr && (&wbits)) |=> (mask == 8'h00)); // R3
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((stat & $past(wbits & ~set_vec & EV_IMPL)) == 8'h00)); // R4
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 8'h00) |-> !irq); // R4
endmodule

// File: rtl/uart_regif.sv
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int ADDR_W     = 4,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ack,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [7:0]        rx_data,
    input  logic              rx_push,
    input  logic              rx_perr,
    output logic [3:0]        cfg_bits,
    output logic [1:0]        cfg_par,
    output logic              irq
);
    localparam logic [CNT_W-1:0] LVL_RST = CNT_W'(FIFO_DEPTH / 2);

    logic             wr_fire, rd_fire;
    logic [31:0]      rd_mux;
    logic [5:0]       mode_q;
    logic [CNT_W-1:0] lvl_q;
    logic [7:0]       stat, mask;
    logic [7:0]       set_vec;

    logic [7:0]       tx_dout, rx_dout;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             tx_empty, tx_full, rx_empty, rx_full;
    logic             tx_empty_d;
    logic             flush_tx, flush_rx;
    logic             tx_push, tx_pop, rx_pop, rx_ok;
    logic             trig_now;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [3:0] idx);
        return a == ADDR_W'(idx);
    endfunction

    uart_regif_bus_fsm u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .rd_mux   (rd_mux),
        .wr_fire  (wr_fire),
        .rd_fire  (rd_fire),
        .bus_rdata(bus_rdata),
        .bus_ack  (bus_ack)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
            lvl_q  <= LVL_RST;
        end else if (wr_fire) begin
            if (hit(bus_addr, IDX_MODE)) mode_q <= bus_wdata[5:0];
            if (hit(bus_addr, IDX_LVL))  lvl_q  <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        unique casez (mode_q[2:1])
            2'b0?:   cfg_bits = 4'd8;
            2'b10:   cfg_bits = 4'd7;
            default: cfg_bits = 4'd6;
        endcase
        if (mode_q[5])      cfg_par = PAR_NONE;
        else if (mode_q[3]) cfg_par = PAR_ODD;
        else                cfg_par = PAR_EVEN;
    end

    // FIFO control
    assign flush_tx = wr_fire && hit(bus_addr, IDX_CTRL) && bus_wdata[0];
    assign flush_rx = wr_fire && hit(bus_addr, IDX_CTRL) && bus_wdata[1];
    assign tx_push  = wr_fire && hit(bus_addr, IDX_DATA);
    assign tx_pop   = tx_valid && tx_ready;
    assign rx_pop   = rd_fire && hit(bus_addr, IDX_DATA);
    assign rx_ok    = rx_push && !rx_full && !flush_rx;

    uart_regif_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush_tx),
        .push(tx_push), .din(bus_wdata[7:0]), .pop(tx_pop),
        .dout(tx_dout), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    uart_regif_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush_rx),
        .push(rx_push), .din(rx_data), .pop(rx_pop),
        .dout(rx_dout), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    assign tx_valid = !tx_empty;
    assign tx_data  = tx_dout;

    // interrupt events
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_empty_d <= 1'b1;
        else        tx_empty_d <= tx_empty;
    end

    assign trig_now = (lvl_q != '0) && (rx_cnt >= lvl_q);

    always_comb begin
        set_vec = 8'h00;
        set_vec[EV_RXTRIG]  = rx_ok && (lvl_q != '0) &&
                              (({1'b0, rx_cnt} + 1'b1) >= {1'b0, lvl_q});
        set_vec[EV_TXEMPTY] = tx_empty && !tx_empty_d;
        set_vec[EV_PERR]    = rx_ok && rx_perr;
    end

    uart_regif_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .en_wr  (wr_fire && hit(bus_addr, IDX_IEN)),
        .dis_wr (wr_fire && hit(bus_addr, IDX_IDIS)),
        .clr_wr (wr_fire && hit(bus_addr, IDX_STAT)),
        .wbits  (bus_wdata[7:0]),
        .stat   (stat),
        .mask   (mask),
        .irq    (irq)
    );

    // read mux
    always_comb begin
        rd_mux = 32'h0;
        if (hit(bus_addr, IDX_MODE))      rd_mux = {26'h0, mode_q};
        else if (hit(bus_addr, IDX_MASK)) rd_mux = {24'h0, mask};
        else if (hit(bus_addr, IDX_STAT)) rd_mux = {24'h0, stat};
        else if (hit(bus_addr, IDX_LVL))  rd_mux = 32'(lvl_q);
        else if (hit(bus_addr, IDX_CHAN))
            rd_mux = {27'h0, tx_full, tx_empty, rx_full, rx_empty, trig_now};
        else if (hit(bus_addr, IDX_DATA)) rd_mux = rx_empty ? 32'h0 : {24'h0, rx_dout};
    end

    AST_RXTRIG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ok && lvl_q == CNT_W'(1)) |=> stat[EV_RXTRIG]); // R5
    AST_TXEMPTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_cnt == CNT_W'(1) && !tx_push) |=> ##1 stat[EV_TXEMPTY]); // R6
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !flush_tx) |=> (tx_valid && $stable(tx_data))); // R8
endmodule

// File: tb/sim_uart_regif.sv
module sim_uart_regif;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_push = 1'b0, rx_perr = 1'b0;
    logic [3:0]  cfg_bits;
    logic [1:0]  cfg_par;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_regif #(.FIFO_DEPTH(DEPTH), .ADDR_W(4)) u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        d = bus_rdata;
        if (!bus_ack) begin
            errors++;
            $display("FAIL R2 ack actual 0 expected 1");
        end
        bus_req = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic rx_send(input logic [7:0] b, input logic pe);
        rx_data = b; rx_perr = pe; rx_push = 1'b1;
        @(posedge clk); @(negedge clk);
        rx_push = 1'b0; rx_perr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 irq", irq, 0);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 ack", bus_ack, 0);
        rd_chk("R1 mask", 4'd4, 0);
        rd_chk("R1 status", 4'd5, 0);
        rd_chk("R1 mode", 4'd1, 32'h20);
        rd_chk("R1 level", 4'd8, DEPTH / 2);
        rd_chk("R1 chan", 4'd11, 32'h0A);
        chk("R7 reset bits", cfg_bits, 8);
        chk("R7 reset par", cfg_par, 2);
    endtask

    task automatic t_handshake;
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 4'd1;
        chk("R2 ack before", bus_ack, 0);
        @(posedge clk); @(negedge clk);
        chk("R2 ack high", bus_ack, 1);
        chk("R2 rdata", bus_rdata, 32'h20);
        bus_req = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R2 ack low", bus_ack, 0);
    endtask

    task automatic t_mode;
        bus_wr(4'd1, 32'h04);
        chk("R7 bits7", cfg_bits, 7);
        chk("R7 even", cfg_par, 0);
        bus_wr(4'd1, 32'h0E);
        chk("R7 bits6", cfg_bits, 6);
        chk("R7 odd", cfg_par, 1);
        bus_wr(4'd1, 32'h02);
        chk("R7 bits8", cfg_bits, 8);
        chk("R7 even2", cfg_par, 0);
        rd_chk("R7 readback", 4'd1, 32'h02);
    endtask

    task automatic t_mask;
        bus_wr(4'd2, 32'h89);
        rd_chk("R3 set", 4'd4, 32'h89);
        bus_wr(4'd3, 32'h01);
        rd_chk("R3 clear one", 4'd4, 32'h88);
        rd_chk("R3 en reads zero", 4'd2, 0);
        rd_chk("R3 dis reads zero", 4'd3, 0);
        bus_wr(4'd3, 32'hFFFF_FFFF);
        rd_chk("R3 clear all", 4'd4, 0);
    endtask

    task automatic t_tx;
        for (int i = 0; i < DEPTH; i++) bus_wr(4'd12, 32'h10 + i);
        chk("R8 tx_valid", tx_valid, 1);
        chk("R8 tx head", tx_data, 8'h10);
        bus_wr(4'd12, 32'h99);
        rd_chk("R9 tx full chan", 4'd11, 32'h12);
        bus_wr(4'd2, 32'h08);
        chk("R4 no irq yet", irq, 0);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R8 tx order", tx_data, 8'h10 + i);
            tx_ready = 1'b1;
            @(posedge clk); @(negedge clk);
        end
        tx_ready = 1'b0;
        chk("R9 dropped write", tx_valid, 0);
        @(posedge clk); @(negedge clk);
        rd_chk("R6 tx empty pend", 4'd5, 32'h08);
        chk("R4 irq on", irq, 1);
        bus_wr(4'd5, 32'h08);
        chk("R4 irq off", irq, 0);
        rd_chk("R4 w1c", 4'd5, 0);
        bus_wr(4'd3, 32'hFF);
    endtask

    task automatic t_rx;
        rx_send(8'hA1, 0); rx_send(8'hA2, 0); rx_send(8'hA3, 0);
        rd_chk("R5 below level", 4'd5, 0);
        rd_chk("R5 chan below", 4'd11, 32'h08);
        rx_send(8'hA4, 0);
        rd_chk("R5 at level", 4'd5, 32'h01);
        rd_chk("R5 chan at", 4'd11, 32'h09);
        rd_chk("R8 rx 1", 4'd12, 32'hA1);
        rd_chk("R8 rx 2", 4'd12, 32'hA2);
        rd_chk("R8 rx 3", 4'd12, 32'hA3);
        rd_chk("R8 rx 4", 4'd12, 32'hA4);
        rd_chk("R9 empty read", 4'd12, 0);
        rd_chk("R9 chan empty", 4'd11, 32'h0A);
        bus_wr(4'd5, 32'h01);
        bus_wr(4'd8, 32'h01);
        rx_send(8'h55, 0);
        rd_chk("R5 level1", 4'd5, 32'h01);
        bus_wr(4'd5, 32'h01);
        rx_send(8'h66, 1);
        rd_chk("R10 perr", 4'd5, 32'h81);
        bus_wr(4'd5, 32'h81);
        for (int i = 0; i < DEPTH - 2; i++) rx_send(8'h70 + i, 0);
        rx_send(8'h7F, 0);
        rd_chk("R9 rx full chan", 4'd11, 32'h0D);
        rd_chk("R10 first kept", 4'd12, 32'h55);
        rd_chk("R10 second kept", 4'd12, 32'h66);
        for (int i = 0; i < DEPTH - 2; i++) rd_chk("R10 rx order", 4'd12, 32'h70 + i);
        rd_chk("R10 extra dropped", 4'd12, 0);
    endtask

    task automatic t_flush;
        bus_wr(4'd12, 32'h31);
        bus_wr(4'd12, 32'h32);
        rx_send(8'h41, 0);
        bus_wr(4'd0, 32'h01);
        chk("R11 tx flushed", tx_valid, 0);
        rd_chk("R11 rx kept", 4'd11, 32'h09);
        bus_wr(4'd0, 32'h02);
        rd_chk("R11 rx flushed", 4'd11, 32'h0A);
        rd_chk("R11 ctrl reads 0", 4'd0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_mode();
        t_mask();
        t_tx();
        t_rx();
        t_flush();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual timeout expected completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule